// File: doc/BRIEF.md
# Two-Channel Current-DAC Control Slave

This block is the digital front end of a pair of bidirectional current-output DACs. It listens on a two-wire serial bus (I2C-compatible) as a slave at one fixed 7-bit address, keeps one control byte per channel, and turns each byte into the three controls an analog current cell needs: a source enable, a sink enable and a 4-bit step magnitude. Each channel can source or sink current in 15 steps, and a magnitude of zero turns the cell off entirely.

SCL and SDA are sampled with the system clock through a synchronizer and a short majority filter. START, repeated START and STOP are recognised as SDA edges while the filtered SCL is high. A host sets a channel with the sequence START, write address, pointer byte, data byte, STOP. It reads a channel back by writing the pointer, sending a repeated START with the read address, taking one byte, and ending with NACK and STOP. SDA is driven only as an open-drain pull-down enable.

Top module: `cdac_ctl_i2c`

## Requirements
- R1: While reset is applied and right after it, every channel has source enable 0, sink enable 0 and magnitude 0, and the SDA pull-down is off.
- R2: A write transaction 0x90, 0xF8, data sets channel 0 from the data byte. Bit 7 is the sign (1 = source, 0 = sink) and bits 3:0 are the magnitude, output on mag_o[3:0].
- R3: A write with pointer 0xF9 sets channel 1, whose magnitude is output on mag_o[7:4]. Channel 0 is left unchanged.
- R4: With a nonzero magnitude, sign 1 asserts only the source enable and sign 0 asserts only the sink enable. The two enables are never high together.
- R5: A magnitude of 0 holds both enables of that channel low, whatever the sign bit and the bits 6:4 hold.
- R6: The slave pulls SDA low during the ninth clock of the address byte, the pointer byte and the data byte of a write to its own address.
- R7: After an address byte other than 0x90 or 0x91, the slave leaves SDA released, and every byte up to the next START is ignored. No register changes.
- R8: A read (pointer write, repeated START, address 0x91) returns the stored byte of the addressed channel MSB first, with bits 6:4 as they were written.
- R9: The slave changes its SDA drive only while SCL is low, never during an SCL high phase.
- R10: A write to a pointer other than 0xF8 or 0xF9 is acknowledged but changes no channel. A read from such a pointer returns 0x00.
- R11: A new control value reaches the channel outputs only after the SCL falling edge that ends the ACK clock of the data byte. Before that edge the old value is still present.
- R12: After the master NACKs the read byte, the slave releases SDA, and the block takes a following write normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| src_en_o | output | 2 | Per-channel source enable |
| snk_en_o | output | 2 | Per-channel sink enable |
| mag_o | output | 8 | Per-channel 4-bit magnitude, channel 0 in bits 3:0 |

## Verification
An edge on a bus line reaches the protocol logic five clocks later, after the two synchronizer flops and the two-sample filter. The SDA pull-down therefore changes about six clocks after the SCL falling edge that triggers it. The channel outputs follow about seven clocks after the falling edge that closes the data ACK: one clock for the write pulse and one for the register. The bench holds every SCL phase for 20 clocks. It reads SDA halfway through each high phase and checks the outputs a full phase after the final falling edge, so each sample lands well after its result is due. For R11 the bench samples once during the ACK high phase, when the old value must still show, and once after the fall.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
  typedef enum logic [3:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_PTR,
    LK_PACK,
    LK_WDAT,
    LK_WACK,
    LK_RDAT,
    LK_RACK
  } link_st_e;
endpackage

// File: rtl/cdac_line_filt.sv
module cdac_line_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE-1:0]        hist_q;
  logic                   level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= {hist_q[VOTE-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       level_q <= 1'b1;
      else if (~|hist_q) level_q <= 1'b0;
    end
  end

  assign level_o = level_q;

  // R9: the filtered level moves only when the whole sample history agrees
  p_filt_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(hist_q) == {VOTE{level_q}}));
endmodule

// File: rtl/cdac_link.sv
module cdac_link
  import cdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int CW = $clog2(DW) + 1;
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  link_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d, ptr_q, ptr_d, wdat_q, wdat_d;
  logic          rw_q, rw_d, oe_q, oe_d, wr_q, wr_d;
  logic          scl_q, sda_q;
  logic          rise, fall, start_ev, stop_ev;

  assign rise     = scl_i & ~scl_q;
  assign fall     = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    wdat_d = wdat_q;
    rw_d   = rw_q;
    oe_d   = oe_q;
    wr_d   = 1'b0;
    if (start_ev) begin
      st_d  = LK_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_ev) begin
      st_d = LK_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        LK_ADDR, LK_PTR, LK_WDAT: begin
          if (rise && cnt_q != FULL) begin
            sh_d  = {sh_q[DW-2:0], sda_i};
            cnt_d = cnt_q + 1'b1;
          end else if (fall && cnt_q == FULL) begin
            cnt_d = '0;
            if (st_q == LK_ADDR) begin
              if (sh_q[DW-1:1] == DEV_ADDR) begin
                rw_d = sh_q[0];
                oe_d = 1'b1;
                st_d = LK_AACK;
              end else begin
                st_d = LK_IDLE;
              end
            end else if (st_q == LK_PTR) begin
              ptr_d = sh_q;
              oe_d  = 1'b1;
              st_d  = LK_PACK;
            end else begin
              wdat_d = sh_q;
              oe_d   = 1'b1;
              st_d   = LK_WACK;
            end
          end
        end
        LK_AACK: if (fall) begin
          if (rw_q) begin
            sh_d  = rd_data_i;
            oe_d  = ~rd_data_i[DW-1];
            cnt_d = '0;
            st_d  = LK_RDAT;
          end else begin
            oe_d = 1'b0;
            st_d = LK_PTR;
          end
        end
        LK_PACK: if (fall) begin
          oe_d = 1'b0;
          st_d = LK_WDAT;
        end
        LK_WACK: if (fall) begin
          oe_d = 1'b0;
          wr_d = 1'b1;
          st_d = LK_IDLE;
        end
        LK_RDAT: if (fall) begin
          if (cnt_q == LAST) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = LK_RACK;
          end else begin
            sh_d  = {sh_q[DW-2:0], 1'b0};
            oe_d  = ~sh_q[DW-2];
            cnt_d = cnt_q + 1'b1;
          end
        end
        LK_RACK: if (fall) st_d = LK_IDLE;
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      wdat_q <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      wr_q   <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      wdat_q <= wdat_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
      wr_q   <= wr_d;
      scl_q  <= scl_i;
      sda_q  <= sda_i;
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_q;
  assign wr_data_o = wdat_q;

  // R9: drive held steady across an SCL high phase
  p_sda_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_q) |-> $stable(oe_q));
  // R7: a released or rejected transfer never pulls SDA
  p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_IDLE) |-> !oe_q);
  // R11: a write pulse follows a falling SCL edge in the data ACK state
  p_commit_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> ($past(st_q) == LK_WACK && $past(scl_q) && !$past(scl_i)));
endmodule

// File: rtl/cdac_regs.sv
module cdac_regs #(
  parameter int NCH = 2,
  parameter int DW = 8,
  parameter logic [DW-1:0] BASE = 8'hF8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   ptr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NCH*DW-1:0] ctl_o
);
  logic [NCH*DW-1:0] ctl_q, ctl_d;
  logic [NCH-1:0]    hit;

  always_comb begin
    for (int i = 0; i < NCH; i++) hit[i] = (ptr_i == BASE + DW'(i));
  end

  always_comb begin
    ctl_d   = ctl_q;
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (wr_en_i && hit[i]) ctl_d[i*DW +: DW] = wdata_i;
      if (hit[i]) rdata_o = ctl_q[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_en_i) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  // R11: control bytes hold unless a write pulse was present
  p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ctl_q));
  // R10: a pointer outside the window leaves every control byte alone
  p_miss_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hit == '0) |=> $stable(ctl_q));
endmodule

// File: rtl/cdac_chan.sv
module cdac_chan #(
  parameter int DW = 8,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ctl_i,
  output logic          src_o,
  output logic          snk_o,
  output logic [MW-1:0] mag_o
);
  logic nz;
  assign nz    = |ctl_i[MW-1:0];
  assign mag_o = ctl_i[MW-1:0];
  assign src_o = nz & ctl_i[DW-1];
  assign snk_o = nz & ~ctl_i[DW-1];

  // R4: the two current directions are exclusive
  p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_o && snk_o));
  // R5: zero magnitude means no current either way
  p_zero_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_o == '0) |-> (!src_o && !snk_o));
endmodule

// File: rtl/cdac_ctl_i2c.sv
module cdac_ctl_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int NCH = 2,
  parameter int DW = 8,
  parameter int MW = 4,
  parameter logic [DW-1:0] REG_BASE = 8'hF8,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NCH-1:0]    src_en_o,
  output logic [NCH-1:0]    snk_en_o,
  output logic [NCH*MW-1:0] mag_o
);
  logic              scl_f, sda_f, wr_en;
  logic [DW-1:0]     ptr, wdata, rdata;
  logic [NCH*DW-1:0] ctl;

  cdac_line_filt #(.SYNC_STAGES(SYNC_STAGES), .VOTE(VOTE)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(scl_i), .level_o(scl_f));
  cdac_line_filt #(.SYNC_STAGES(SYNC_STAGES), .VOTE(VOTE)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(sda_i), .level_o(sda_f));

  cdac_link #(.DEV_ADDR(DEV_ADDR), .DW(DW)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
    .rd_data_i(rdata), .sda_oe_o(sda_oe_o), .ptr_o(ptr),
    .wr_en_o(wr_en), .wr_data_o(wdata));

  cdac_regs #(.NCH(NCH), .DW(DW), .BASE(REG_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .ptr_i(ptr),
    .wdata_i(wdata), .rdata_o(rdata), .ctl_o(ctl));

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    cdac_chan #(.DW(DW), .MW(MW)) u_chan (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl[g*DW +: DW]),
      .src_o(src_en_o[g]), .snk_o(snk_en_o[g]), .mag_o(mag_o[g*MW +: MW]));
  end
endmodule

// File: tb/cdac_ctl_i2c_tb.sv
module cdac_ctl_i2c_tb;
  localparam int Q = 20;
  localparam int WDOG = 150000;
  localparam logic [15:0] VEC [8] = '{
    16'hF88A, 16'hF905, 16'hF8F0, 16'hF980,
    16'hF873, 16'hF9CF, 16'hF800, 16'hF9BE};

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe;
  logic [1:0] src_en, snk_en;
  logic [7:0] mag;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0, cyc = 0, r9_viol = 0;
  logic scl_d, oe_d;
  logic [7:0] mdl [2];

  always #2 clk = ~clk;

  cdac_ctl_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .src_en_o(src_en), .snk_en_o(snk_en), .mag_o(mag));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    scl_d <= scl_m;
    oe_d  <= sda_oe;
    if (rst_n && scl_m && scl_d && sda_oe !== oe_d) r9_viol <= r9_viol + 1;
    if (cyc == WDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q / 2); b = sda_bus; wq(Q / 2);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(1'b1);
  endtask

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte(8'h90, acks[2]);
    send_byte(p, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte(8'h90, acks[2]);
    send_byte(p, acks[1]);
    bus_rstart();
    send_byte(8'h91, acks[0]);
    recv_byte(d);
  endtask

  task automatic check_outs(input string tag);
    for (int c = 0; c < 2; c++) begin
      chk({tag, " src"}, 32'(src_en[c]), 32'(mdl[c][7] & (|mdl[c][3:0])));
      chk({tag, " snk"}, 32'(snk_en[c]), 32'(~mdl[c][7] & (|mdl[c][3:0])));
      chk({tag, " mag"}, 32'(mag[c*4 +: 4]), 32'(mdl[c][3:0]));
    end
  endtask

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    logic       a;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    mdl[0] = 8'h00; mdl[1] = 8'h00;
    wq(5);
    chk("R1 oe in reset", 32'(sda_oe), 0);
    check_outs("R1 in reset");
    rst_n = 1'b1;
    wq(10);
    check_outs("R1 after reset");

    // table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 8; i++) begin
      logic [7:0] p, d;
      p = VEC[i][15:8];
      d = VEC[i][7:0];
      write_reg(p, d, acks);
      chk("R6 write acks", 32'(acks), 32'h7);
      mdl[p[0]] = d;
      check_outs(p[0] ? "R3 R4 R5 ch1 write" : "R2 R4 R5 ch0 write");
      read_reg(p, rd, acks);
      chk("R8 readback", 32'(rd), 32'(d));
      chk("R8 read acks", 32'(acks), 32'h7);
      chk("R12 released after NACK", 32'(sda_oe), 0);
      bus_stop();
    end

    // R7: foreign address, following bytes ignored
    bus_start();
    send_byte(8'h92, a);
    chk("R7 no ack on foreign address", 32'(a), 0);
    send_byte(8'hF8, a);
    chk("R7 pointer byte ignored", 32'(a), 0);
    send_byte(8'h85, a);
    chk("R7 data byte ignored", 32'(a), 0);
    bus_stop();
    check_outs("R7 outputs unchanged");

    // R10: pointer outside the window
    write_reg(8'h10, 8'h8F, acks);
    chk("R10 write acked", 32'(acks), 32'h7);
    check_outs("R10 outputs unchanged");
    read_reg(8'h10, rd, acks);
    chk("R10 read returns zero", 32'(rd), 0);
    bus_stop();

    // R11: value appears only after the data ACK clock falls
    bus_start();
    send_byte(8'h90, a);
    send_byte(8'hF8, a);
    for (int i = 7; i >= 0; i--) bit_out(8'h8C >> i);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q / 2);
    chk("R11 ack during data ACK", 32'(sda_bus), 0);
    chk("R11 old magnitude during ACK", 32'(mag[3:0]), 32'(mdl[0][3:0]));
    wq(Q / 2); scl_m = 1'b0; wq(Q);
    mdl[0] = 8'h8C;
    chk("R11 new magnitude after ACK", 32'(mag[3:0]), 32'hC);
    chk("R11 new source after ACK", 32'(src_en[0]), 1);
    bus_stop();

    // R12: a write right after a NACK-terminated read
    read_reg(8'hF9, rd, acks);
    chk("R12 oe after NACK", 32'(sda_oe), 0);
    bus_stop();
    write_reg(8'hF9, 8'h07, acks);
    mdl[1] = 8'h07;
    chk("R12 write after read acked", 32'(acks), 32'h7);
    check_outs("R12 R3 write after read");

    chk("R9 SDA drive changes during SCL high", r9_viol, 0);

    // R1: reset mid-run clears the channels
    wq(3);
    rst_n = 1'b0;
    wq(2);
    mdl[0] = 8'h00; mdl[1] = 8'h00;
    check_outs("R1 reset after writes");
    rst_n = 1'b1;
    wq(10);
    check_outs("R1 after second reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule